// File: doc/BRIEF.md
# Dual-Source System Clock Controller

This block decides which oscillator paces the processor. The fast main oscillator can drive it through one of four divide ratios. The slow subsystem oscillator can drive it through a fixed divide by four. The block turns the ticks of the chosen oscillator into a one-cycle machine-cycle strobe. The processor core and the rest of the chip use that strobe as their clock enable. Oscillator activity is modelled as tick pulses on a common fabric clock. The oscillator-enable and oscillator-running signals are ordinary digital ports.

Software sets the block through two write-only fields. A divider field picks the main-clock speed. A system field has a source-select bit (bit 0) and a main-oscillator-stop bit (bit 3).

After reset the processor is held in reset until the main oscillator has run for a long stabilisation wait. The processor then starts at the slowest main speed. A source change is staged: the old source keeps producing strobes until a fixed number of its machine cycles have passed, and only then does the new source take over. A stop request is held back while the main clock is still in use. A return to the main clock waits for the restarted oscillator to stabilise.

Top module: `clkctl_top`

## Requirements
- R1: After `rst_ni` rises, `cpu_rst_o` stays high until 2^STAB_W main ticks have been counted. It falls one cycle later, never rises again before the next reset, and `mc_stb_o` is low while it is high.
- R2: In and after reset the main source is active (`sub_active_o`=0), `busy_o`=0, `main_osc_en_o`=1, and a machine cycle is 64 main ticks.
- R3: A divider write takes `wdata_i[1:0]`: 00 gives 64 main ticks per machine cycle, 01 gives 16, 10 gives 8 and 11 gives 4.
- R4: While the subsystem source is active, a machine cycle is 4 subsystem ticks.
- R5: A system write sets the requested source from `wdata_i[0]` (1 = subsystem). `busy_o` is high from the next cycle while the request differs from the active source. `sub_active_o` changes only after SW_CYC machine-cycle strobes of the old source, and it is otherwise stable. Writing the active source back before that point cancels the switch.
- R6: `sub_ready_o` is `sub_run_i` passed through two flops. A request for the subsystem source is ignored while `sub_ready_o` is low.
- R7: `wdata_i[3]` of a system write is the stop request. `main_osc_en_o` falls only while the subsystem source is active. A stop written together with a switch to the subsystem takes effect only once that switch has completed.
- R8: A request to return to the main source makes no progress while the main oscillator is stopped. Once the stop bit is cleared, `main_osc_en_o` rises at once. The switch then counts SW_CYC strobes only after 2^STAB_W main ticks have restabilised the oscillator.
- R9: `mc_stb_o` is high only in a cycle that carries a tick of the active source, and it lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | fabric clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| main_tick_i | input | 1 | one pulse per main oscillator period |
| sub_tick_i | input | 1 | one pulse per subsystem oscillator period |
| sub_run_i | input | 1 | subsystem oscillator running |
| wr_pcc_i | input | 1 | write strobe for the divider field |
| wr_scc_i | input | 1 | write strobe for the system field |
| wdata_i | input | 4 | write data |
| cpu_rst_o | output | 1 | holds the processor in reset |
| mc_stb_o | output | 1 | machine-cycle strobe |
| sub_active_o | output | 1 | 1 while the subsystem source drives the strobe |
| busy_o | output | 1 | source switch pending |
| main_osc_en_o | output | 1 | main oscillator enable |
| sub_ready_o | output | 1 | synchronised subsystem running status |

## Verification
The strobe generator is driven through a table that covers every divider code. Each code shows as a distinct strobe period, so a wrong decode or an off-by-one compare gives a different count.

The source switch is tried in four ways:
- a plain switch to the subsystem, where exactly SW_CYC old-source strobes are counted;
- a request made while the subsystem oscillator is absent, which must leave the source unchanged;
- a return to the main clock while the oscillator is stopped, which must stall indefinitely;
- a switch reversed midway, which must cancel.

The stop bit is written together with the switch. This separates the case where the stop is held back from the case where it is applied at once.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int DIV_W = 7;

  typedef enum logic [1:0] {
    PCC_DIV64 = 2'b00,
    PCC_DIV16 = 2'b01,
    PCC_DIV8  = 2'b10,
    PCC_DIV4  = 2'b11
  } pcc_sel_e;

  localparam logic [DIV_W-1:0] SUB_DIV = 7'd4;

  function automatic logic [DIV_W-1:0] pcc_div(pcc_sel_e s);
    case (s)
      PCC_DIV64: pcc_div = 7'd64;
      PCC_DIV16: pcc_div = 7'd16;
      PCC_DIV8:  pcc_div = 7'd8;
      default:   pcc_div = 7'd4;
    endcase
  endfunction
endpackage

// File: rtl/clkctl_stab.sv
module clkctl_stab #(
  parameter int STAB_W = 17
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_en_i,
  input  logic tick_i,
  output logic ready_o,
  output logic boot_o
);
  logic [STAB_W-1:0] cnt_q;
  logic              ready_q;
  logic              boot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
      boot_q  <= 1'b0;
    end else begin
      boot_q <= boot_q | ready_q;
      if (!osc_en_i) begin
        cnt_q   <= '0;
        ready_q <= 1'b0;
      end else if (tick_i && !ready_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == '1) ready_q <= 1'b1;
      end
    end
  end

  assign ready_o = ready_q;
  assign boot_o  = boot_q;
endmodule

// File: rtl/clkctl_mcgen.sv
module clkctl_mcgen
  import clkctl_pkg::*;
#(
  parameter int CNT_W = DIV_W - 1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     main_tick_i,
  input  logic     sub_tick_i,
  input  logic     osc_en_i,
  input  logic     hold_i,
  input  logic     src_sub_i,
  input  pcc_sel_e pcc_i,
  output logic     stb_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             src_q;
  logic             tick;
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] cnt_ext;
  logic             wrap;

  assign tick    = src_sub_i ? sub_tick_i : (main_tick_i & osc_en_i);
  assign lim     = src_sub_i ? SUB_DIV : pcc_div(pcc_i);
  assign cnt_ext = {{(DIV_W-CNT_W){1'b0}}, cnt_q};
  assign wrap    = cnt_ext >= (lim - 1'b1);
  assign stb_o   = tick & ~hold_i & wrap & (src_q == src_sub_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      src_q <= 1'b0;
    end else begin
      src_q <= src_sub_i;
      if (src_q != src_sub_i) begin
        cnt_q <= '0;
      end else if (tick && !hold_i) begin
        cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkctl_switch.sv
module clkctl_switch #(
  parameter int SW_CYC = 32,
  localparam int SW_W  = (SW_CYC > 1) ? $clog2(SW_CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic sel_i,
  input  logic stop_i,
  input  logic sub_ok_i,
  input  logic main_ok_i,
  input  logic stb_i,
  output logic act_sub_o,
  output logic busy_o,
  output logic stop_o
);
  logic            req_q;
  logic            act_q;
  logic            stop_q;
  logic [SW_W-1:0] cnt_q;
  logic            tgt_ok;
  logic            busy;

  assign busy   = req_q != act_q;
  assign tgt_ok = req_q ? sub_ok_i : main_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      stop_q <= 1'b0;
    end else if (wr_i) begin
      stop_q <= stop_i;
      if (!(sel_i && !sub_ok_i)) req_q <= sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (!busy) begin
      cnt_q <= '0;
    end else if (stb_i && tgt_ok) begin
      if (cnt_q == SW_W'(SW_CYC - 1)) begin
        act_q <= req_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign act_sub_o = act_q;
  assign busy_o    = busy;
  assign stop_o    = stop_q;
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int STAB_W = 17,
  parameter int SW_CYC = 32,
  parameter int SYNC_N = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       main_tick_i,
  input  logic       sub_tick_i,
  input  logic       sub_run_i,
  input  logic       wr_pcc_i,
  input  logic       wr_scc_i,
  input  logic [3:0] wdata_i,
  output logic       cpu_rst_o,
  output logic       mc_stb_o,
  output logic       sub_active_o,
  output logic       busy_o,
  output logic       main_osc_en_o,
  output logic       sub_ready_o
);
  pcc_sel_e          pcc_q;
  logic [SYNC_N-1:0] sync_q;
  logic              sub_ok;
  logic              main_ok;
  logic              boot;
  logic              act_sub;
  logic              stop_q;
  logic              osc_en;
  logic              stb;
  logic              busy;
  logic              unused_wd;

  assign unused_wd = wdata_i[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_N-2:0], sub_run_i};
  end
  assign sub_ok = sync_q[SYNC_N-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pcc_q <= PCC_DIV64;
    else if (wr_pcc_i) pcc_q <= pcc_sel_e'(wdata_i[1:0]);
  end

  // stop only bites once the subsystem source owns the strobe
  assign osc_en = ~(stop_q & act_sub);

  clkctl_stab #(.STAB_W(STAB_W)) u_stab (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .osc_en_i (osc_en),
    .tick_i   (main_tick_i),
    .ready_o  (main_ok),
    .boot_o   (boot)
  );

  clkctl_mcgen u_mcgen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .main_tick_i (main_tick_i),
    .sub_tick_i  (sub_tick_i),
    .osc_en_i    (osc_en),
    .hold_i      (~boot),
    .src_sub_i   (act_sub),
    .pcc_i       (pcc_q),
    .stb_o       (stb)
  );

  clkctl_switch #(.SW_CYC(SW_CYC)) u_switch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_scc_i),
    .sel_i     (wdata_i[0]),
    .stop_i    (wdata_i[3]),
    .sub_ok_i  (sub_ok),
    .main_ok_i (main_ok),
    .stb_i     (stb),
    .act_sub_o (act_sub),
    .busy_o    (busy),
    .stop_o    (stop_q)
  );

  assign cpu_rst_o     = ~boot;
  assign mc_stb_o      = stb;
  assign sub_active_o  = act_sub;
  assign busy_o        = busy;
  assign main_osc_en_o = osc_en;
  assign sub_ready_o   = sub_ok;
endmodule

// File: rtl/clkctl_chk.sv
module clkctl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic main_tick_i,
  input logic sub_tick_i,
  input logic cpu_rst_o,
  input logic mc_stb_o,
  input logic sub_active_o,
  input logic busy_o,
  input logic main_osc_en_o
);
  AST_BOOT_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_rst_o |=> !cpu_rst_o); // R1
  AST_NO_STB_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_o |-> !mc_stb_o); // R1
  AST_SRC_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(sub_active_o)); // R5
  AST_CLK_ALIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sub_active_o |-> main_osc_en_o); // R7
  AST_STB_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_stb_o |-> (sub_active_o ? sub_tick_i : main_tick_i)); // R9
endmodule

bind clkctl_top clkctl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .main_tick_i   (main_tick_i),
  .sub_tick_i    (sub_tick_i),
  .cpu_rst_o     (cpu_rst_o),
  .mc_stb_o      (mc_stb_o),
  .sub_active_o  (sub_active_o),
  .busy_o        (busy_o),
  .main_osc_en_o (main_osc_en_o)
);

// File: tb/clkctl_top_tb.sv
`timescale 1ns/1ps
module clkctl_top_tb;
  localparam int STAB_W = 4;
  localparam int SW_CYC = 32;
  localparam int VEC[4][2] = '{'{1, 16}, '{2, 8}, '{3, 4}, '{0, 64}};

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       main_tick_i = 1'b1;
  logic       sub_tick_i;
  logic       sub_run_i = 1'b1;
  logic       wr_pcc_i = 1'b0;
  logic       wr_scc_i = 1'b0;
  logic [3:0] wdata_i = '0;
  logic       cpu_rst_o, mc_stb_o, sub_active_o, busy_o, main_osc_en_o, sub_ready_o;
  logic [2:0] sdiv = '0;
  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) sdiv <= sdiv + 3'd1;
  assign sub_tick_i = (sdiv == 3'd7);

  clkctl_top #(.STAB_W(STAB_W), .SW_CYC(SW_CYC)) u_dut (
    .clk_i, .rst_ni, .main_tick_i, .sub_tick_i, .sub_run_i, .wr_pcc_i, .wr_scc_i,
    .wdata_i, .cpu_rst_o, .mc_stb_o, .sub_active_o, .busy_o, .main_osc_en_o, .sub_ready_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit scc, input logic [3:0] d);
    @(negedge clk_i);
    wr_scc_i = scc; wr_pcc_i = !scc; wdata_i = d;
    @(negedge clk_i);
    wr_scc_i = 1'b0; wr_pcc_i = 1'b0;
  endtask

  task automatic period(output int p);
    do @(negedge clk_i); while (!mc_stb_o);
    p = 0;
    do begin @(negedge clk_i); p++; end while (!mc_stb_o);
  endtask

  task automatic strobes_until(input logic want_sub, output int n);
    n = 0;
    while (sub_active_o != want_sub) begin
      if (mc_stb_o) n++;
      @(negedge clk_i);
    end
  endtask

  initial begin
    #3_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, p;
    repeat (3) @(negedge clk_i);
    chk(cpu_rst_o && !mc_stb_o, "R1 reset hold", cpu_rst_o, 1);
    chk(!sub_active_o && !busy_o && main_osc_en_o, "R2 reset state",
        {sub_active_o, busy_o, main_osc_en_o}, 1);
    rst_ni = 1'b1;
    n = 0;
    while (cpu_rst_o) begin @(posedge clk_i); #1; n++; end
    chk(n == (1 << STAB_W) + 1, "R1 boot wait", n, (1 << STAB_W) + 1);
    period(p);
    chk(p == 64, "R2 default period", p, 64);

    for (int i = 0; i < 4; i++) begin
      wr(1'b0, 4'(VEC[i][0]));
      period(p);
      chk(p == VEC[i][1], "R3 divider code", p, VEC[i][1]);
    end
    wr(1'b0, 4'd3);

    // R6: request rejected without subsystem oscillator
    sub_run_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(!sub_ready_o, "R6 ready low", sub_ready_o, 0);
    wr(1'b1, 4'b0001);
    repeat (20) @(negedge clk_i);
    chk(!busy_o && !sub_active_o, "R6 ignored", {busy_o, sub_active_o}, 0);
    sub_run_i = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(sub_ready_o, "R6 ready high", sub_ready_o, 1);

    // R5/R7: switch with stop held back
    wr(1'b1, 4'b1001);
    chk(busy_o && main_osc_en_o, "R7 stop held while busy", {busy_o, main_osc_en_o}, 3);
    strobes_until(1'b1, n);
    chk(n == SW_CYC, "R5 switch delay", n, SW_CYC);
    chk(!busy_o && !main_osc_en_o, "R7 stop applied", {busy_o, main_osc_en_o}, 0);
    period(p);
    chk(p == 32, "R4 sub period", p, 32);

    // R8: return deferred while stopped
    wr(1'b1, 4'b1000);
    repeat (1500) @(negedge clk_i);
    chk(sub_active_o && busy_o && !main_osc_en_o, "R8 deferred",
        {sub_active_o, busy_o, main_osc_en_o}, 6);
    wr(1'b1, 4'b0000);
    chk(main_osc_en_o, "R8 osc restart", main_osc_en_o, 1);
    strobes_until(1'b0, n);
    chk(n == SW_CYC || n == SW_CYC + 1, "R8 return after stab", n, SW_CYC);
    period(p);
    chk(p == 4, "R9 main period after return", p, 4);
    @(negedge clk_i);
    chk(!mc_stb_o, "R9 one-cycle strobe", mc_stb_o, 0);

    // R5: cancel midway
    wr(1'b1, 4'b0001);
    repeat (40) @(negedge clk_i);
    wr(1'b1, 4'b0000);
    chk(!busy_o, "R5 cancel busy", busy_o, 0);
    repeat (300) @(negedge clk_i);
    chk(!sub_active_o && main_osc_en_o, "R5 cancel source", sub_active_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule